// File: doc/BRIEF.md
# Receive Descriptor DMA Engine

This engine takes frame data from a receive FIFO and stores it in memory buffers that software describes with a list of four-word descriptors. Software writes a list base address and raises an enable. The engine then walks the list, taking only descriptors whose ownership bit is set. It copies FIFO words into the buffers of each descriptor. When it is done with a descriptor, it writes the status word back with ownership cleared and segment flags set, in the same write.

A frame may spread over several descriptors. The engine moves on when a frame ends or when the current descriptor's buffers are full. Ring layout places descriptors every 16 bytes and wraps to the base address at an end-of-ring mark. Chain layout follows a link address held in each descriptor. If the engine meets a descriptor it does not own, it suspends and waits for a poll pulse before it reads that descriptor again. When a frame cannot continue, flush mode closes it with an error flag and discards the rest of its words.

Descriptor layout, with all addresses and sizes in 32-bit words:
- Word 0 is status.
- Word 1 is control.
- Word 2 is the first buffer address.
- Word 3 is the second buffer address in ring layout, or the link in chain layout.

Top module: `rxdesc_dma`

## Requirements
- R1: After synchronous reset, the engine is stopped: `mem_req`, `fifo_pop` and `suspended` are 0 and `cur_desc` is 0.
- R2: When `rx_en` is 1 while stopped, the engine latches `desc_base` into `cur_desc` on that edge. It then reads status word 0 at that address.
- R3: When a status word has bit 31 (ownership) at 0, the engine asserts `suspended`. While suspended it makes no memory access and no FIFO pop, and `cur_desc` does not change.
- R4: Data words go to consecutive word addresses starting at the first buffer address, up to the size in control bits [11:0]. In ring layout, the second buffer (word 3) follows, up to the size in control bits [23:12], if that size is nonzero.
- R5: When the word that carries `fifo_eof` has been stored, the engine writes word 0 of the current descriptor. The written value has bit 31 = 0, bit 30 = first-segment, bit 29 = 1 (last segment) and bits [15:0] = the number of words stored in that descriptor. The engine then reads the next descriptor.
- R6: When the buffers fill before the frame ends and the next descriptor is owned, the engine closes the current descriptor with bit 29 = 0. The frame continues in the next descriptor, whose status is written with bit 30 = 0.
- R7: When the buffers fill before the frame ends, the next descriptor is not owned and `flush_en` = 1, the current descriptor is closed with bits 29 and 28 (error) set. The remaining words of the frame, up to and including the `fifo_eof` word, are popped without being written. The engine then suspends on the next descriptor.
- R8: In the same case with `flush_en` = 0, the current descriptor is closed with bits 29 and 28 clear, and the engine suspends on the next descriptor. After a poll finds that descriptor owned, the same frame resumes with bit 30 = 0.
- R9: In ring layout (control bit 24 = 0), the next descriptor is at the current address + 16. When control bit 25 (end of ring) is set, it is the latched base address instead.
- R10: In chain layout (control bit 24 = 1), the next descriptor is word 3 with bits [1:0] cleared, and the second buffer size is ignored. Every memory access uses a word-aligned address.
- R11: A `poll` pulse while suspended reads word 0 of `cur_desc` again. If ownership is still 0, the engine suspends again at the same address.
- R12: `frame_done` is high for exactly one cycle for each status write that has bit 29 set.
- R13: When `rx_en` is 0 while the engine is suspended, the engine returns to stopped. While stopped it ignores `poll` and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; starts the engine and, when low while suspended, stops it |
| flush_en | input | 1 | Discard the rest of a frame that runs out of descriptors |
| poll | input | 1 | Re-poll pulse while suspended |
| desc_base | input | 32 | Byte address of the first descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the cycle `mem_gnt` is high |
| mem_gnt | input | 1 | Access accepted this cycle |
| fifo_valid | input | 1 | FIFO has a word |
| fifo_data | input | 32 | FIFO head word |
| fifo_eof | input | 1 | Head word is the last of its frame |
| fifo_pop | output | 1 | Remove head word this cycle |
| suspended | output | 1 | Engine is waiting on a descriptor it does not own |
| cur_desc | output | 32 | Address of the current descriptor |
| frame_done | output | 1 | One-cycle pulse when a last segment is closed |

## Verification
The bench targets these corner cases:
- A frame that crosses from the first buffer into the second. A design that ignores the second buffer would write past the first one.
- A chain descriptor with a nonzero second size. A design that honoured that size would write data to the link address.
- Running out of descriptors mid-frame, with flush on and with flush off:
  - If the drain went wrong, it would eat into the following frame, or leave part of the flushed one in the FIFO.
  - If the resume went wrong, it would set first-segment again, or start a new frame.
- Poll while still unowned, end-of-ring wrap, and stop while suspended. A fault here would show as stray memory traffic or a wrong `cur_desc`.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = 4;
    localparam int DESC_BYTES = 16;
    localparam int SZ_W       = 12;
    localparam int CNT_W      = 16;

    // status word bit positions
    localparam int ST_OWN = 31;
    localparam int ST_FS  = 30;
    localparam int ST_LS  = 29;
    localparam int ST_ERR = 28;

    // control word bit positions
    localparam int CT_CHAIN = 24;
    localparam int CT_EOR   = 25;

    typedef enum logic [3:0] {
        S_STOP, S_RD0, S_RD1, S_RD2, S_RD3,
        S_XFER, S_PEEK, S_CLOSE, S_DRAIN, S_SUSP
    } state_e;

    typedef struct packed {
        logic            chain;
        logic            eor;
        logic [SZ_W-1:0] sz2;
        logic [SZ_W-1:0] sz1;
    } ctrl_t;

    typedef struct packed {
        logic   ls;
        logic   err;
        state_e after;
    } close_t;

    function automatic ctrl_t decode_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.chain = w[CT_CHAIN];
        c.eor   = w[CT_EOR];
        c.sz2   = w[2*SZ_W-1:SZ_W];
        c.sz1   = w[SZ_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] make_status(input logic fs,
                                                      input logic ls,
                                                      input logic err,
                                                      input logic [CNT_W-1:0] cnt);
        logic [WORD_W-1:0] s;
        s            = '0;
        s[ST_FS]     = fs;
        s[ST_LS]     = ls;
        s[ST_ERR]    = err;
        s[CNT_W-1:0] = cnt;
        return s;
    endfunction

endpackage

// File: rtl/rxd_walk.sv
module rxd_walk
    import rxd_pkg::*;
#(
    parameter int AW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] base_in,
    input  logic          advance,
    input  logic          chain,
    input  logic          eor,
    input  logic          ld_link,
    input  logic [AW-1:0] link_in,
    output logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    logic [AW-1:0] base_q;
    logic [AW-1:0] link_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            base_q <= '0;
            link_q <= '0;
        end else begin
            if (start) begin
                cur    <= base_in;
                base_q <= base_in;
            end else if (advance) begin
                cur <= nxt;
            end
            if (ld_link) link_q <= link_in;
        end
    end

    always_comb begin
        if (chain)    nxt = {link_q[AW-1:2], 2'b00};
        else if (eor) nxt = base_q;
        else          nxt = cur + AW'(DESC_BYTES);
    end
endmodule

// File: rtl/rxd_bufctl.sv
module rxd_bufctl
    import rxd_pkg::*;
#(
    parameter int AW  = WORD_W,
    parameter int SZW = SZ_W,
    parameter int CW  = CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [AW-1:0]  b1_addr,
    input  logic [SZW-1:0] b1_size,
    input  logic [AW-1:0]  b2_addr,
    input  logic [SZW-1:0] b2_size,
    input  logic           b2_en,
    input  logic           step,
    output logic [AW-1:0]  wr_addr,
    output logic [CW-1:0]  count,
    output logic           at_end
);
    logic [SZW-1:0] left;
    logic           b2_pend;
    logic [AW-1:0]  b2_q;
    logic [SZW-1:0] b2sz_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr <= '0;
            count   <= '0;
            left    <= '0;
            b2_pend <= 1'b0;
            b2_q    <= '0;
            b2sz_q  <= '0;
        end else if (load) begin
            wr_addr <= {b1_addr[AW-1:2], 2'b00};
            left    <= b1_size;
            b2_pend <= b2_en && (b2_size != '0);
            b2_q    <= {b2_addr[AW-1:2], 2'b00};
            b2sz_q  <= b2_size;
            count   <= '0;
        end else if (step) begin
            count <= count + CW'(1);
            if (left == SZW'(1) && b2_pend) begin
                wr_addr <= b2_q;
                left    <= b2sz_q;
                b2_pend <= 1'b0;
            end else begin
                wr_addr <= wr_addr + AW'(WORD_BYTES);
                left    <= left - SZW'(1);
            end
        end
    end

    assign at_end = (left == SZW'(1)) && !b2_pend;
endmodule

// File: rtl/rxdesc_dma.sv
module rxdesc_dma
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              flush_en,
    input  logic              poll,
    input  logic [WORD_W-1:0] desc_base,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_gnt,
    input  logic              fifo_valid,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic              fifo_eof,
    output logic              fifo_pop,
    output logic              suspended,
    output logic [WORD_W-1:0] cur_desc,
    output logic              frame_done
);
    localparam logic [WORD_W-1:0] OFS1 = WORD_W'(WORD_BYTES);
    localparam logic [WORD_W-1:0] OFS2 = WORD_W'(2 * WORD_BYTES);
    localparam logic [WORD_W-1:0] OFS3 = WORD_W'(3 * WORD_BYTES);

    state_e            st;
    close_t            cl;
    ctrl_t             ctl_q;
    ctrl_t             ctl_now;
    logic              first_q;
    logic              in_frame;
    logic [WORD_W-1:0] b1_q;
    logic [WORD_W-1:0] cur;
    logic [WORD_W-1:0] nxt;
    logic [WORD_W-1:0] wr_addr;
    logic [CNT_W-1:0]  count;
    logic              at_end;
    logic              walk_start;
    logic              advance;
    logic              ld_desc;
    logic              step;

    assign ctl_now    = decode_ctrl(mem_rdata);
    assign walk_start = (st == S_STOP) && rx_en;
    assign advance    = (st == S_CLOSE) && mem_gnt;
    assign ld_desc    = (st == S_RD3) && mem_gnt;
    assign step       = (st == S_XFER) && fifo_valid && mem_gnt;

    rxd_walk #(.AW(WORD_W)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .start   (walk_start),
        .base_in (desc_base),
        .advance (advance),
        .chain   (ctl_q.chain),
        .eor     (ctl_q.eor),
        .ld_link (ld_desc),
        .link_in (mem_rdata),
        .cur     (cur),
        .nxt     (nxt)
    );

    rxd_bufctl #(.AW(WORD_W), .SZW(SZ_W), .CW(CNT_W)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .load    (ld_desc),
        .b1_addr (b1_q),
        .b1_size (ctl_q.sz1),
        .b2_addr (mem_rdata),
        .b2_size (ctl_q.sz2),
        .b2_en   (!ctl_q.chain),
        .step    (step),
        .wr_addr (wr_addr),
        .count   (count),
        .at_end  (at_end)
    );

    // memory and FIFO side, decoded from the state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        fifo_pop  = 1'b0;
        unique case (st)
            S_RD0: begin mem_req = 1'b1; mem_addr = cur;        end
            S_RD1: begin mem_req = 1'b1; mem_addr = cur + OFS1; end
            S_RD2: begin mem_req = 1'b1; mem_addr = cur + OFS2; end
            S_RD3: begin mem_req = 1'b1; mem_addr = cur + OFS3; end
            S_XFER: begin
                mem_req   = fifo_valid;
                mem_we    = 1'b1;
                mem_addr  = wr_addr;
                mem_wdata = fifo_data;
                fifo_pop  = fifo_valid && mem_gnt;
            end
            S_PEEK: begin mem_req = 1'b1; mem_addr = nxt; end
            S_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur;
                mem_wdata = make_status(first_q, cl.ls, cl.err, count);
            end
            S_DRAIN: fifo_pop = fifo_valid;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_STOP;
            cl       <= '{ls: 1'b0, err: 1'b0, after: S_STOP};
            ctl_q    <= '0;
            first_q  <= 1'b0;
            in_frame <= 1'b0;
            b1_q     <= '0;
        end else begin
            unique case (st)
                S_STOP: if (rx_en) begin
                    st       <= S_RD0;
                    in_frame <= 1'b0;
                end
                S_RD0: if (mem_gnt) st <= mem_rdata[ST_OWN] ? S_RD1 : S_SUSP;
                S_RD1: if (mem_gnt) begin
                    ctl_q <= ctl_now;
                    st    <= S_RD2;
                end
                S_RD2: if (mem_gnt) begin
                    b1_q <= mem_rdata;
                    st   <= S_RD3;
                end
                S_RD3: if (mem_gnt) begin
                    first_q <= !in_frame;
                    st      <= S_XFER;
                end
                S_XFER: if (step) begin
                    in_frame <= 1'b1;
                    if (fifo_eof) begin
                        cl       <= '{ls: 1'b1, err: 1'b0, after: S_RD0};
                        in_frame <= 1'b0;
                        st       <= S_CLOSE;
                    end else if (at_end) begin
                        st <= S_PEEK;
                    end
                end
                S_PEEK: if (mem_gnt) begin
                    if (mem_rdata[ST_OWN]) begin
                        cl <= '{ls: 1'b0, err: 1'b0, after: S_RD0};
                    end else if (flush_en) begin
                        cl       <= '{ls: 1'b1, err: 1'b1, after: S_DRAIN};
                        in_frame <= 1'b0;
                    end else begin
                        cl <= '{ls: 1'b0, err: 1'b0, after: S_SUSP};
                    end
                    st <= S_CLOSE;
                end
                S_CLOSE: if (mem_gnt) st <= cl.after;
                S_DRAIN: if (fifo_valid && fifo_eof) st <= S_SUSP;
                S_SUSP: begin
                    if (!rx_en)    st <= S_STOP;
                    else if (poll) st <= S_RD0;
                end
                default: st <= S_STOP;
            endcase
        end
    end

    assign suspended  = (st == S_SUSP);
    assign cur_desc   = cur;
    assign frame_done = (st == S_CLOSE) && mem_gnt && cl.ls;
endmodule

// File: rtl/rxdesc_dma_chk.sv
module rxdesc_dma_chk
    import rxd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_gnt,
    input logic              fifo_valid,
    input logic              fifo_pop,
    input logic              suspended,
    input logic [WORD_W-1:0] cur_desc,
    input logic              frame_done
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_req && !fifo_pop && !suspended));

    a_r3_no_traffic_suspended: assert property (@(posedge clk) disable iff (rst)
        suspended |-> (!mem_req && !fifo_pop));

    a_r3_desc_held: assert property (@(posedge clk) disable iff (rst)
        (suspended && $past(suspended)) |-> $stable(cur_desc));

    a_r7_pop_needs_word: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> fifo_valid);

    a_r10_word_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    a_r12_one_cycle: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    a_r5_done_on_close: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (mem_req && mem_we && mem_gnt && mem_wdata[ST_LS] && !mem_wdata[ST_OWN]));
endmodule

bind rxdesc_dma rxdesc_dma_chk u_chk (.*);

// File: tb/rxdesc_dma_test.sv
module rxdesc_dma_test;
    import rxd_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_en = 1'b0;
    logic        flush_en = 1'b0;
    logic        poll = 1'b0;
    logic [31:0] desc_base = 32'h100;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_gnt = 1'b1;
    logic        fifo_valid = 1'b0;
    logic [31:0] fifo_data = '0;
    logic        fifo_eof = 1'b0;
    logic        fifo_pop;
    logic        suspended;
    logic [31:0] cur_desc;
    logic        frame_done;

    always #10 clk = ~clk;

    rxdesc_dma uut (.*);

    typedef struct {
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } wr_t;

    typedef struct packed {
        logic        eof;
        logic [31:0] d;
    } fw_t;

    logic [31:0] mem [0:1023];
    wr_t         sb[$];
    fw_t         fq[$];
    int          checks = 0;
    int          errors = 0;
    int          done_cnt = 0;
    int          gcnt = 0;

    assign mem_rdata = mem[mem_addr[11:2]];

    // memory model, scoreboard monitor and FIFO model
    always @(posedge clk) begin
        wr_t e;
        if (mem_req && mem_gnt && mem_we) begin
            mem[mem_addr[11:2]] = mem_wdata;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R3: unexpected write addr %h data %h, expected no write", mem_addr, mem_wdata);
            end else begin
                e = sb.pop_front();
                if (e.addr !== mem_addr || e.data !== mem_wdata) begin
                    errors++;
                    $display("FAIL %s: write addr %h data %h, expected addr %h data %h",
                             e.tag, mem_addr, mem_wdata, e.addr, e.data);
                end
            end
        end
        if (fifo_pop && fq.size() > 0) void'(fq.pop_front());
        fifo_valid <= (fq.size() > 0);
        fifo_data  <= (fq.size() > 0) ? fq[0].d : 32'h0;
        fifo_eof   <= (fq.size() > 0) ? fq[0].eof : 1'b0;
        gcnt++;
        mem_gnt <= (gcnt % 5) != 3;
    end

    always @(negedge clk) if (!rst && frame_done) done_cnt++;

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic logic [31:0] mk_ctrl(input int sz1, input int sz2, input bit chain, input bit eor);
        logic [31:0] c;
        c = '0;
        c[11:0]     = 12'(sz1);
        c[23:12]    = 12'(sz2);
        c[CT_CHAIN] = chain;
        c[CT_EOR]   = eor;
        return c;
    endfunction

    task automatic set_desc(input logic [31:0] a, input bit own, input logic [31:0] ctrl,
                            input logic [31:0] b1, input logic [31:0] w3);
        mem[a[11:2]]     = {own, 31'h0};
        mem[a[11:2] + 1] = ctrl;
        mem[a[11:2] + 2] = b1;
        mem[a[11:2] + 3] = w3;
    endtask

    task automatic push_frame(input int n, input logic [31:0] first);
        for (int i = 0; i < n; i++) fq.push_back('{eof: (i == n - 1), d: first + 32'(i)});
    endtask

    task automatic expw(input logic [31:0] a, input logic [31:0] d, input string tag);
        sb.push_back('{addr: a, data: d, tag: tag});
    endtask

    task automatic pulse_poll();
        @(negedge clk) poll = 1'b1;
        @(negedge clk) poll = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(suspended && sb.size() == 0) && n < 3000);
        check(n < 3000, $sformatf("%s: not settled, suspended=%0d pending=%0d, expected suspended=1 pending=0",
                                  tag, suspended, sb.size()));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL ALL: watchdog expired, run still busy, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!mem_req && !fifo_pop && !suspended && cur_desc == 0,
              $sformatf("R1: req=%0d pop=%0d susp=%0d cur=%h, expected 0 0 0 0",
                        mem_req, fifo_pop, suspended, cur_desc));
        repeat (4) @(negedge clk);
        check(!mem_req, $sformatf("R13: stopped engine req=%0d, expected 0", mem_req));

        // ring list: buffer 1 then buffer 2, then a second frame, then an unowned slot
        set_desc(32'h100, 1, mk_ctrl(4, 2, 0, 0), 32'h400, 32'h500);
        set_desc(32'h110, 1, mk_ctrl(8, 0, 0, 0), 32'h600, 32'h0);
        set_desc(32'h120, 0, mk_ctrl(2, 0, 0, 1), 32'h700, 32'h0);
        push_frame(5, 32'hA000_0000);
        push_frame(3, 32'hB000_0000);
        for (int i = 0; i < 4; i++) expw(32'h400 + 32'(4 * i), 32'hA000_0000 + 32'(i), "R4");
        expw(32'h500, 32'hA000_0004, "R4");
        expw(32'h100, 32'h6000_0005, "R5");
        for (int i = 0; i < 3; i++) expw(32'h600 + 32'(4 * i), 32'hB000_0000 + 32'(i), "R4");
        expw(32'h110, 32'h6000_0003, "R5");
        @(negedge clk) rx_en = 1'b1;
        @(negedge clk);
        check(cur_desc == 32'h100 && mem_req && !mem_we && mem_addr == 32'h100,
              $sformatf("R2: cur=%h req=%0d we=%0d addr=%h, expected cur=100 req=1 we=0 addr=100",
                        cur_desc, mem_req, mem_we, mem_addr));
        wait_idle("R3");
        check(cur_desc == 32'h120, $sformatf("R9: cur=%h, expected 120", cur_desc));
        check(done_cnt == 2, $sformatf("R12: frame_done cycles=%0d, expected 2", done_cnt));

        // poll while still unowned
        pulse_poll();
        check(!suspended && mem_req && mem_addr == 32'h120,
              $sformatf("R11: susp=%0d req=%0d addr=%h, expected 0 1 120", suspended, mem_req, mem_addr));
        repeat (10) @(negedge clk);
        check(suspended && cur_desc == 32'h120,
              $sformatf("R11: susp=%0d cur=%h, expected 1 120", suspended, cur_desc));

        // no flush: frame stalls at end of ring, then resumes
        set_desc(32'h120, 1, mk_ctrl(2, 0, 0, 1), 32'h700, 32'h0);
        push_frame(4, 32'hC000_0000);
        expw(32'h700, 32'hC000_0000, "R8");
        expw(32'h704, 32'hC000_0001, "R8");
        expw(32'h120, 32'h4000_0002, "R8");
        pulse_poll();
        wait_idle("R8");
        check(cur_desc == 32'h100, $sformatf("R9: wrap cur=%h, expected 100", cur_desc));
        check(fq.size() == 2, $sformatf("R8: words left in FIFO=%0d, expected 2", fq.size()));
        set_desc(32'h100, 1, mk_ctrl(4, 0, 0, 0), 32'h800, 32'h0);
        expw(32'h800, 32'hC000_0002, "R8");
        expw(32'h804, 32'hC000_0003, "R8");
        expw(32'h100, 32'h2000_0002, "R8");
        pulse_poll();
        wait_idle("R8");
        check(cur_desc == 32'h110, $sformatf("R8: cur=%h, expected 110", cur_desc));
        check(done_cnt == 3, $sformatf("R12: frame_done cycles=%0d, expected 3", done_cnt));

        // flush: rest of frame dropped, next frame kept
        flush_en = 1'b1;
        set_desc(32'h110, 1, mk_ctrl(2, 0, 0, 0), 32'h900, 32'h0);
        push_frame(5, 32'hD000_0000);
        push_frame(2, 32'hE000_0000);
        expw(32'h900, 32'hD000_0000, "R7");
        expw(32'h904, 32'hD000_0001, "R7");
        expw(32'h110, 32'h7000_0002, "R7");
        pulse_poll();
        wait_idle("R7");
        check(cur_desc == 32'h120, $sformatf("R7: cur=%h, expected 120", cur_desc));
        check(fq.size() == 2, $sformatf("R7: words left in FIFO=%0d, expected 2", fq.size()));
        check(done_cnt == 4, $sformatf("R12: frame_done cycles=%0d, expected 4", done_cnt));

        // chain layout: second size ignored, link followed
        set_desc(32'h120, 1, mk_ctrl(1, 3, 1, 0), 32'hA00, 32'h303);
        set_desc(32'h300, 1, mk_ctrl(4, 0, 1, 0), 32'hB00, 32'h100);
        expw(32'hA00, 32'hE000_0000, "R10");
        expw(32'h120, 32'h4000_0001, "R6");
        expw(32'hB00, 32'hE000_0001, "R10");
        expw(32'h300, 32'h2000_0001, "R6");
        pulse_poll();
        wait_idle("R10");
        check(cur_desc == 32'h100, $sformatf("R10: cur=%h, expected 100", cur_desc));
        check(done_cnt == 5, $sformatf("R12: frame_done cycles=%0d, expected 5", done_cnt));

        // stop from suspend, ignore poll, restart at a new base
        @(negedge clk) rx_en = 1'b0;
        @(negedge clk);
        check(!suspended && !mem_req, $sformatf("R13: susp=%0d req=%0d, expected 0 0", suspended, mem_req));
        pulse_poll();
        repeat (4) @(negedge clk);
        check(!mem_req && !suspended, $sformatf("R13: after poll req=%0d susp=%0d, expected 0 0", mem_req, suspended));
        desc_base = 32'h200;
        @(negedge clk) rx_en = 1'b1;
        repeat (8) @(negedge clk);
        check(suspended && cur_desc == 32'h200,
              $sformatf("R2: susp=%0d cur=%h, expected 1 200", suspended, cur_desc));
        check(sb.size() == 0, $sformatf("R5: pending writes=%0d, expected 0", sb.size()));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule